// File: doc/BRIEF.md
# ADC Start-Trigger Selector

This block decides when an analog-to-digital converter controller may begin a conversion. A 2-bit source code picks one of four trigger sources: a software start bit, the compare-match flags of an eight-flag multi-channel timer, the compare-match flags of a four-flag timer, or an external trigger pin. Every timer flag has its own enable. The external pin must pass two qualifiers: an enable and a pin-direction bit. The block then issues a single-cycle start pulse.

The register fields reach the block as plain ports. A write of 1 to the start bit arrives as a one-cycle `start_set` strobe, and a software clear arrives as `start_clr`. In software mode the strobe starts a conversion at once. The start bit then stays high until the converter reports completion. In the two timer modes and the external mode the start bit arms the unit and stays set until software clears it. The selected event then fires the conversion. Triggers that arrive while the converter reports busy are dropped, not queued.

Top module: `adc_trig_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `conv_start` and `armed` are 0.
- R2: `mode_sel` selects the source as follows: 2'b00 software, 2'b01 eight-flag timer, 2'b10 four-flag timer, 2'b11 external pin. Events from any source that is not selected never cause a start.
- R3: In mode 2'b00, a `start_set` strobe in cycle t drives `conv_start` high in cycle t+1 and sets `armed`, provided `conv_busy` is low and no pulse is in progress.
- R4: `start_clr` clears `armed` in every mode. In mode 2'b00, `conv_done` also clears it. If `start_set` arrives in the same cycle as either, `start_set` wins.
- R5: In mode 2'b01 with `armed` high, a 0-to-1 change of `mt_flag[i]` while `mt_en[i]` is 1 drives `conv_start` high in the next cycle. Bits [3:0] are compare A–D of timer channel 0, and bits [7:4] are compare A–D of channel 1. A flag that stays high does not fire again, and a flag whose enable is 0 never fires.
- R6: In mode 2'b10 with `armed` high, a 0-to-1 change of `qt_flag[i]` (bits A–D at [3:0]) while `qt_en[i]` is 1 drives `conv_start` high in the next cycle.
- R7: In modes 2'b01, 2'b10 and 2'b11, no start occurs while `armed` is 0. In these modes `armed` stays set after `conv_done`.
- R8: In mode 2'b11 with `armed`, `ext_en` and `ext_dir_in` all 1, a 1-to-0 change on `ext_pin` before edge k passes through two synchroniser flops and a history flop. `conv_start` is then high after edge k+2. If either qualifier is 0, nothing fires.
- R9: `conv_start` is never high for two cycles in a row. An event seen while `conv_busy` is high is dropped. `trig_busy` is high whenever `conv_start` or `conv_busy` is high.
- R10: In a cycle where `mode_sel` differs from its value in the previous cycle, timer and pin events cause no start. A flag level that was already high before the change is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Trigger source code |
| start_set | input | 1 | Strobe: software wrote 1 to the start bit |
| start_clr | input | 1 | Strobe: software cleared the start bit |
| mt_flag | input | 8 | Compare-match flags of the multi-channel timer |
| mt_en | input | 8 | Per-flag trigger enables, multi-channel timer |
| qt_flag | input | 4 | Compare-match flags of the four-channel timer |
| qt_en | input | 4 | Per-flag trigger enables, four-channel timer |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| ext_en | input | 1 | External trigger input enable |
| ext_dir_in | input | 1 | Shared pin configured as input |
| conv_busy | input | 1 | Converter is converting |
| conv_done | input | 1 | Converter completion strobe |
| conv_start | output | 1 | One-cycle conversion start pulse |
| armed | output | 1 | Current value of the start bit |
| trig_busy | output | 1 | Start pending or converter busy |

## Verification
Directed sequences cover the following cases:
- A single enabled flag rising, then held high, which separates edge detection from level detection.
- A disabled flag rising, which exposes a missing per-flag enable.
- A flag of the timer that is not selected rising, which exposes a source-decode fault.
- The pin falling with the direction qualifier off and then on, which checks both the gating and the exact three-cycle synchroniser latency.

Further cases cover a flag rising while the converter is busy, and a flag rising in the very cycle the mode changes, which checks the history blanking. A long seeded random run then changes modes, enables, flags, pin and converter status together. Each cycle is compared against a cycle-level reference model in the bench, which catches interactions between arming, self-clearing and busy dropping that the directed cases miss.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    // Source codes: other logic decodes these values, so they are fixed.
    typedef enum logic [1:0] {
        SRC_SW   = 2'b00,
        SRC_MTMR = 2'b01,
        SRC_QTMR = 2'b10,
        SRC_EXT  = 2'b11
    } trig_src_e;

    typedef struct packed {
        trig_src_e mode;   // source code seen in the previous cycle
        logic      armed;  // start bit
        logic      pulse;  // registered start pulse
    } ctl_state_t;

endpackage

// File: rtl/trig_edge.sv
// Rising-edge detector over a vector of flags, each gated by its own enable.
module trig_edge #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flags,
    input  logic [WIDTH-1:0] enables,
    input  logic             blank,
    output logic             hit
);

    logic [WIDTH-1:0] prev_d, prev_q;
    logic [WIDTH-1:0] rise;

    always_comb begin
        prev_d = flags;
        rise   = flags & ~prev_q & enables;
        hit    = (|rise) & ~blank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/ext_fall_det.sv
// Synchronises an asynchronous pin and flags a qualified falling edge.
module ext_fall_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic qual,
    input  logic blank,
    output logic fall
);

    localparam int CHAIN = SYNC_STAGES + 1;  // synchroniser plus one history flop

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], pin};
        fall    = chain_q[CHAIN-1] & ~chain_q[CHAIN-2] & qual & ~blank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;   // idle-high pin: no edge out of reset
        end else begin
            chain_q <= chain_d;
        end
    end

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_trig_pkg::*;
#(
    parameter int MT_FLAGS    = 8,
    parameter int QT_FLAGS    = 4,
    parameter int EXT_SYNC    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_sel,
    input  logic                start_set,
    input  logic                start_clr,
    input  logic [MT_FLAGS-1:0] mt_flag,
    input  logic [MT_FLAGS-1:0] mt_en,
    input  logic [QT_FLAGS-1:0] qt_flag,
    input  logic [QT_FLAGS-1:0] qt_en,
    input  logic                ext_pin,
    input  logic                ext_en,
    input  logic                ext_dir_in,
    input  logic                conv_busy,
    input  logic                conv_done,
    output logic                conv_start,
    output logic                armed,
    output logic                trig_busy
);

    ctl_state_t st_d, st_q;
    trig_src_e  mode_in;
    logic       blank;
    logic       mt_hit, qt_hit, ext_hit;
    logic       event_sel;

    assign mode_in = trig_src_e'(mode_sel);
    assign blank   = (mode_in != st_q.mode);

    trig_edge #(.WIDTH(MT_FLAGS)) u_mt_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (mt_flag),
        .enables (mt_en),
        .blank   (blank),
        .hit     (mt_hit)
    );

    trig_edge #(.WIDTH(QT_FLAGS)) u_qt_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (qt_flag),
        .enables (qt_en),
        .blank   (blank),
        .hit     (qt_hit)
    );

    ext_fall_det #(.SYNC_STAGES(EXT_SYNC)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .qual  (ext_en & ext_dir_in),
        .blank (blank),
        .fall  (ext_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_in;

        unique case (mode_in)
            SRC_SW:   event_sel = start_set;
            SRC_MTMR: event_sel = st_q.armed & mt_hit;
            SRC_QTMR: event_sel = st_q.armed & qt_hit;
            SRC_EXT:  event_sel = st_q.armed & ext_hit;
            default:  event_sel = 1'b0;
        endcase

        // Events are dropped while the converter is busy or a pulse is out.
        st_d.pulse = event_sel & ~conv_busy & ~st_q.pulse;

        if (start_clr) begin
            st_d.armed = 1'b0;
        end
        if (mode_in == SRC_SW && conv_done) begin
            st_d.armed = 1'b0;
        end
        if (start_set) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: SRC_SW, armed: 1'b0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_start = st_q.pulse;
    assign armed      = st_q.armed;
    assign trig_busy  = st_q.pulse | conv_busy;

endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       start_set,
    input logic       conv_busy,
    input logic       conv_done,
    input logic       conv_start,
    input logic       armed
);

    // R9: start is a single-cycle pulse
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R9: an event while the converter is busy is dropped
    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> !conv_start);

    // R3: software strobe starts a conversion next cycle
    assert_sw_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && start_set && !conv_busy && !conv_start) |=> conv_start);

    // R4: completion clears the start bit in software mode
    assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && conv_done && !start_set) |=> !armed);

    // R7: hardware sources need the unit armed
    assert_need_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b00 && !armed) |=> !conv_start);

    // R10: no hardware-sourced start in a cycle where the mode changed
    assert_mode_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b00 && mode_sel != $past(mode_sel)) |=> !conv_start);

endmodule

bind adc_trig_sel adc_trig_sel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .start_set  (start_set),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .armed      (armed)
);

// File: tb/tb_adc_trig_sel.sv
module tb_adc_trig_sel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       start_set = 1'b0, start_clr = 1'b0;
    logic [7:0] mt_flag = '0, mt_en = '0;
    logic [3:0] qt_flag = '0, qt_en = '0;
    logic       ext_pin = 1'b1, ext_en = 1'b0, ext_dir_in = 1'b0;
    logic       conv_busy = 1'b0, conv_done = 1'b0;
    logic       conv_start, armed, trig_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    adc_trig_sel dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .start_set(start_set), .start_clr(start_clr),
        .mt_flag(mt_flag), .mt_en(mt_en), .qt_flag(qt_flag), .qt_en(qt_en),
        .ext_pin(ext_pin), .ext_en(ext_en), .ext_dir_in(ext_dir_in),
        .conv_busy(conv_busy), .conv_done(conv_done),
        .conv_start(conv_start), .armed(armed), .trig_busy(trig_busy)
    );

    // Cycle-level reference model built from the requirements.
    logic [1:0] m_mode;
    logic       m_armed, m_pulse;
    logic [7:0] m_mprev;
    logic [3:0] m_qprev;
    logic       m_s1, m_s2, m_s3;

    function automatic logic model_event(input logic [1:0] md, input logic blk,
                                         input logic arm, input logic sset,
                                         input logic mh, input logic qh, input logic ef);
        case (md)
            2'b00:   return sset;
            2'b01:   return arm & mh & ~blk;
            2'b10:   return arm & qh & ~blk;
            default: return arm & ef & ~blk;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 2'b00; m_armed = 0; m_pulse = 0;
            m_mprev = '0; m_qprev = '0;
            m_s1 = 1; m_s2 = 1; m_s3 = 1;
        end else begin
            logic blk, mh, qh, ef, ev, na;
            blk = (mode_sel != m_mode);
            mh  = |(mt_flag & ~m_mprev & mt_en);
            qh  = |(qt_flag & ~m_qprev & qt_en);
            ef  = m_s3 & ~m_s2 & ext_en & ext_dir_in;
            ev  = model_event(mode_sel, blk, m_armed, start_set, mh, qh, ef);
            na  = m_armed;
            if (start_clr) na = 0;
            if (mode_sel == 2'b00 && conv_done) na = 0;
            if (start_set) na = 1;
            m_pulse = ev & ~conv_busy & ~m_pulse;
            m_armed = na;
            m_mode  = mode_sel;
            m_mprev = mt_flag;
            m_qprev = qt_flag;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'b00:   return "R3";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R8";
        endcase
    endfunction

    initial begin
        int seed;
        seed = $urandom(20240611);
        cyc();
        chk("R1", "conv_start in reset", conv_start, 1'b0);
        chk("R1", "armed in reset", armed, 1'b0);
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1", "conv_start after reset", conv_start, 1'b0);
        chk("R1", "armed after reset", armed, 1'b0);

        // Software start (R3, R4, R9)
        start_set = 1; cyc(); start_set = 0;
        chk("R3", "sw start pulse", conv_start, 1'b1);
        chk("R3", "sw armed", armed, 1'b1);
        chk("R9", "trig_busy with pulse", trig_busy, 1'b1);
        cyc();
        chk("R9", "pulse is one cycle", conv_start, 1'b0);
        conv_done = 1; cyc(); conv_done = 0;
        chk("R4", "done clears armed in sw", armed, 1'b0);

        // Multi-channel timer (R5, R7)
        mode_sel = 2'b01; cyc();
        start_set = 1; cyc(); start_set = 0;
        chk("R7", "arming alone no start", conv_start, 1'b0);
        mt_en = 8'h08; mt_flag = 8'h08; cyc();
        chk("R5", "enabled flag rise", conv_start, 1'b1);
        cyc();
        chk("R5", "held level no retrigger", conv_start, 1'b0);
        cyc();
        chk("R5", "held level still quiet", conv_start, 1'b0);
        mt_flag = 8'h18; cyc();
        chk("R5", "disabled flag rise", conv_start, 1'b0);
        conv_done = 1; cyc(); conv_done = 0;
        chk("R7", "armed kept after done", armed, 1'b1);
        start_clr = 1; cyc(); start_clr = 0;
        chk("R4", "start_clr clears armed", armed, 1'b0);
        mt_flag = 8'h00; cyc();
        mt_flag = 8'h08; cyc();
        chk("R7", "unarmed timer edge", conv_start, 1'b0);

        // Four-channel timer (R6, R2, R9)
        mode_sel = 2'b10; cyc();
        start_set = 1; cyc(); start_set = 0;
        qt_en = 4'b0100; qt_flag = 4'b0001; cyc();
        chk("R6", "disabled qt flag", conv_start, 1'b0);
        qt_flag = 4'b0101; cyc();
        chk("R6", "enabled qt flag rise", conv_start, 1'b1);
        mt_en = 8'hFF; mt_flag = 8'h09; cyc();
        chk("R2", "other timer ignored", conv_start, 1'b0);
        qt_flag = 4'b0000; cyc();
        conv_busy = 1; qt_flag = 4'b0100; cyc();
        chk("R9", "busy drops event", conv_start, 1'b0);
        chk("R9", "trig_busy follows conv_busy", trig_busy, 1'b1);
        conv_busy = 0; cyc();
        chk("R9", "dropped event not queued", conv_start, 1'b0);

        // Mode change blanking (R10)
        mode_sel = 2'b01; cyc();
        chk("R10", "stale levels after change", conv_start, 1'b0);
        cyc();
        chk("R10", "stale levels later", conv_start, 1'b0);
        qt_flag = 4'b0000; cyc();
        mode_sel = 2'b10; qt_flag = 4'b0100; cyc();
        chk("R10", "edge in change cycle", conv_start, 1'b0);

        // External pin (R8)
        mode_sel = 2'b11; ext_en = 1; ext_dir_in = 0; cyc();
        ext_pin = 0; cyc(); cyc(); cyc();
        chk("R8", "direction qualifier blocks", conv_start, 1'b0);
        ext_pin = 1; cyc(); cyc(); cyc();
        ext_dir_in = 1; ext_pin = 0; cyc();
        chk("R8", "latency cycle 1", conv_start, 1'b0);
        cyc();
        chk("R8", "latency cycle 2", conv_start, 1'b0);
        cyc();
        chk("R8", "fall fires after sync", conv_start, 1'b1);
        cyc();
        chk("R8", "single fire on low level", conv_start, 1'b0);

        // Seeded random run against the model.
        for (int n = 0; n < 4000; n++) begin
            chk(mode_tag(mode_sel), "random conv_start", conv_start, m_pulse);
            chk("R4", "random armed", armed, m_armed);
            chk("R9", "random trig_busy", trig_busy, m_pulse | conv_busy);
            if ($urandom % 24 == 0) mode_sel = 2'($urandom);
            start_set = ($urandom % 10 == 0);
            start_clr = ($urandom % 40 == 0);
            if ($urandom % 30 == 0) mt_en = 8'($urandom);
            if ($urandom % 30 == 0) qt_en = 4'($urandom);
            if ($urandom % 4 == 0) mt_flag = mt_flag ^ (8'h1 << ($urandom % 8));
            if ($urandom % 4 == 0) qt_flag = qt_flag ^ (4'h1 << ($urandom % 4));
            if ($urandom % 5 == 0) ext_pin = ~ext_pin;
            if ($urandom % 50 == 0) ext_en = ~ext_en;
            if ($urandom % 50 == 0) ext_dir_in = ~ext_dir_in;
            conv_busy = ($urandom % 4 == 0);
            conv_done = ($urandom % 8 == 0);
            cyc();
        end

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule